// File: doc/BRIEF.md
# In-Place Implication Logic Engine

A cycle-level model of a small bank of one-bit storage cells that compute in place with material implication. Each cell holds a bit until something writes to it, and there is no refresh. A command port writes a given value into a cell, forces a cell to 0 or to 1, or applies an implication from a source cell onto a target cell. The target cell keeps the result, so it can be the operand of the next command without being written again.

An implication can only move its target from 0 to 1. A target that is already 1 stays at 1, and a cell goes back to 0 only through an explicit clear. A start strobe runs a NAND macro over three cells: two operand cells and one working cell that ends up holding the result. The macro takes three cycles: it clears the working cell, applies the first operand onto it, and then applies the second operand onto it. While it runs, busy is high and every other request is ignored. A one-cycle done pulse marks the end of the macro, and a one-cycle error pulse marks a rejected request. Any cell can be read combinationally through a readback address.

Top module: `imply_engine`

## Requirements
- R1: While rst_ni is low, and after it is released, every cell reads 0 and busy_o, done_o and err_o are low.
- R2: An accepted command with cmd_op_i = 00 writes load_val_i into cell dst_i, with 01 writes 0, and with 10 writes 1. The new value is visible on rd_data_o after the clock edge that accepts the command.
- R3: An accepted command with cmd_op_i = 11 (implication) writes (NOT cell[src_a_i]) OR cell[dst_i] into cell dst_i, and leaves cell src_a_i unchanged.
- R4: An implication never changes a target cell from 1 to 0.
- R5: An implication with src_a_i equal to dst_i is rejected: err_o is high for the following cycle and no cell changes.
- R6: A cell that is not the target of an accepted write keeps its value.
- R7: When nand_start_i is accepted, the working cell dst_i reads its old value for one cycle, then 0, then NOT cell[src_a_i], then the NAND of cells src_a_i and src_b_i. busy_o is high for the first three of those cycles, and done_o is high for exactly the fourth. Both operand cells are unchanged.
- R8: A start whose dst_i equals src_a_i or src_b_i is rejected: err_o pulses for one cycle, busy_o stays low and no cell changes.
- R9: While busy_o is high, commands and start strobes are ignored. The only cell written during a macro is its working cell.
- R10: When nand_start_i and cmd_valid_i are high in the same cycle, the start is taken and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Single command request |
| cmd_op_i | input | 2 | 00 write value, 01 clear, 10 set, 11 implication |
| src_a_i | input | 3 | Implication source; first NAND operand |
| src_b_i | input | 3 | Second NAND operand |
| dst_i | input | 3 | Command target; NAND working cell |
| load_val_i | input | 1 | Value for the write-value command |
| nand_start_i | input | 1 | Launches the NAND macro |
| rd_addr_i | input | 3 | Readback address |
| rd_data_o | output | 1 | Combinational value of cell rd_addr_i |
| busy_o | output | 1 | Macro in progress |
| done_o | output | 1 | One-cycle pulse after the macro's last step |
| err_o | output | 1 | One-cycle pulse for a rejected request |

## Verification
A single command shows its result on readback and err_o one edge after the cycle in which it is driven. A NAND macro has results due on the four edges that follow its start: the working cell's old value, then 0, then the inverted first operand, then the final value together with done_o. The driver turns each stimulus into expected items stamped with the cycle number in which they fall due. The monitor compares an item only on the falling edge of that cycle. An item still unchecked once its cycle has passed counts as a mismatch.

// File: rtl/imply_pkg.sv
package imply_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_CLEAR = 2'b01,
    OP_SET   = 2'b10,
    OP_IMPLY = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WIPE,
    ST_STEP_P,
    ST_STEP_Q
  } seq_e;
endpackage

// File: rtl/imply_bank.sv
module imply_bank #(
  parameter int N_CELLS = 8,
  localparam int AW = $clog2(N_CELLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_val_i,
  input  logic [AW-1:0] rd_a_addr_i,
  input  logic [AW-1:0] rd_b_addr_i,
  input  logic [AW-1:0] rd_x_addr_i,
  output logic          rd_a_o,
  output logic          rd_b_o,
  output logic          rd_x_o
);
  logic cell_q [N_CELLS];

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cell_q[i] <= 1'b0;
      else if (wr_en_i && wr_addr_i == AW'(i)) cell_q[i] <= wr_val_i;
    end

    assert_retain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == AW'(i)) |=> $stable(cell_q[i]));
  end

  assign rd_a_o = cell_q[rd_a_addr_i];
  assign rd_b_o = cell_q[rd_b_addr_i];
  assign rd_x_o = cell_q[rd_x_addr_i];
endmodule

// File: rtl/imply_ctrl.sv
module imply_ctrl
  import imply_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic [AW-1:0] dst_i,
  input  logic          data_i,
  input  logic          start_i,
  input  logic          rd_a_i,
  input  logic          rd_b_i,
  output logic [AW-1:0] rd_a_addr_o,
  output logic [AW-1:0] rd_b_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_val_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  seq_e          st_q, st_d;
  logic [AW-1:0] p_q, q_q, w_q;
  logic          done_q, err_q;
  logic          idle, start_bad, imply_bad, is_imp;
  op_e           op;

  assign op        = op_e'(op_i);
  assign idle      = (st_q == ST_IDLE);
  assign start_bad = (dst_i == src_a_i) || (dst_i == src_b_i);
  assign imply_bad = (op == OP_IMPLY) && (src_a_i == dst_i);

  always_comb begin
    st_d        = st_q;
    rd_a_addr_o = src_a_i;
    rd_b_addr_o = dst_i;
    wr_en_o     = 1'b0;
    wr_addr_o   = dst_i;
    wr_val_o    = 1'b0;
    is_imp      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (!start_bad) st_d = ST_WIPE;
        end else if (cmd_valid_i) begin
          wr_en_o = !imply_bad;
          unique case (op)
            OP_LOAD:  wr_val_o = data_i;
            OP_CLEAR: wr_val_o = 1'b0;
            OP_SET:   wr_val_o = 1'b1;
            OP_IMPLY: begin
              wr_val_o = !rd_a_i | rd_b_i;
              is_imp   = 1'b1;
            end
            default:  wr_val_o = 1'b0;
          endcase
        end
      end
      ST_WIPE: begin
        wr_en_o   = 1'b1;
        wr_addr_o = w_q;
        st_d      = ST_STEP_P;
      end
      ST_STEP_P, ST_STEP_Q: begin
        rd_a_addr_o = (st_q == ST_STEP_P) ? p_q : q_q;
        rd_b_addr_o = w_q;
        wr_en_o     = 1'b1;
        wr_addr_o   = w_q;
        wr_val_o    = !rd_a_i | rd_b_i;
        is_imp      = 1'b1;
        st_d        = (st_q == ST_STEP_P) ? ST_STEP_Q : ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      p_q    <= '0;
      q_q    <= '0;
      w_q    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_STEP_Q);
      err_q  <= idle && ((start_i && start_bad) ||
                         (!start_i && cmd_valid_i && imply_bad));
      if (idle && start_i) begin
        p_q <= src_a_i;
        q_q <= src_b_i;
        w_q <= dst_i;
      end
    end
  end

  assign busy_o = !idle;
  assign done_o = done_q;
  assign err_o  = err_q;

  assert_src_not_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_imp && wr_en_o) |-> (wr_addr_o != rd_a_addr_o));
  assert_no_clear_by_imply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_imp && wr_en_o && rd_b_i) |-> wr_val_o);
  assert_reject_stays_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o ##1 busy_o ##1 !busy_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(st_q == ST_STEP_Q) && !busy_o));
  assert_busy_only_w_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wr_en_o) |-> (wr_addr_o == w_q));
endmodule

// File: rtl/imply_engine.sv
module imply_engine #(
  parameter int N_CELLS = 8,
  localparam int AW = $clog2(N_CELLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic [AW-1:0] dst_i,
  input  logic          load_val_i,
  input  logic          nand_start_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_data_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;
  logic          rd_a, rd_b, wr_en, wr_val;

  imply_ctrl #(.AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .op_i        (cmd_op_i),
    .src_a_i     (src_a_i),
    .src_b_i     (src_b_i),
    .dst_i       (dst_i),
    .data_i      (load_val_i),
    .start_i     (nand_start_i),
    .rd_a_i      (rd_a),
    .rd_b_i      (rd_b),
    .rd_a_addr_o (rd_a_addr),
    .rd_b_addr_o (rd_b_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_val_o    (wr_val),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  imply_bank #(.N_CELLS(N_CELLS)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_val_i    (wr_val),
    .rd_a_addr_i (rd_a_addr),
    .rd_b_addr_i (rd_b_addr),
    .rd_x_addr_i (rd_addr_i),
    .rd_a_o      (rd_a),
    .rd_b_o      (rd_b),
    .rd_x_o      (rd_data_o)
  );
endmodule

// File: tb/tb_imply_engine.sv
module tb_imply_engine;
  timeunit 1ns;
  timeprecision 10ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [2:0] src_a = '0, src_b = '0, dst = '0, rd_addr = '0;
  logic       load_val = 1'b0, nand_start = 1'b0;
  logic       rd_data, busy, done, err;

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 1'b0;
  logic model [8];

  typedef struct {
    int         due;
    logic [2:0] addr;
    logic       val;
    bit         flags;
    logic       busy, done, err;
    string      req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imply_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .src_a_i(src_a), .src_b_i(src_b), .dst_i(dst), .load_val_i(load_val),
    .nand_start_i(nand_start), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic push(int due, logic [2:0] a, logic v, bit f,
                      logic b, logic d, logic e, string req);
    item_t it;
    it.due = due; it.addr = a; it.val = v; it.flags = f;
    it.busy = b; it.done = d; it.err = e; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: compares each item on the falling edge of its due cycle
  always begin
    @(negedge clk);
    if (rst_n) begin
      for (int i = 0; i < sb.size();) begin
        if (sb[i].due == cyc) begin
          rd_addr = sb[i].addr;
          #0.2;
          compared++;
          if (rd_data !== sb[i].val ||
              (sb[i].flags && (busy !== sb[i].busy || done !== sb[i].done || err !== sb[i].err))) begin
            mismatched++;
            $display("FAIL %s cyc %0d cell%0d: got val=%b busy=%b done=%b err=%b, exp val=%b busy=%b done=%b err=%b",
                     sb[i].req, cyc, sb[i].addr, rd_data, busy, done, err,
                     sb[i].val, sb[i].busy, sb[i].done, sb[i].err);
          end
          sb.delete(i);
        end else if (sb[i].due < cyc) begin
          compared++; mismatched++;
          $display("FAIL %s: item for cell%0d missed (due %0d, now %0d), exp %b, got none",
                   sb[i].req, sb[i].addr, sb[i].due, cyc, sb[i].val);
          sb.delete(i);
        end else i++;
      end
    end
  end

  task automatic check_bank(string req);
    for (int i = 0; i < 8; i++) push(cyc + 1, 3'(i), model[i], 1'b0, 1'b0, 1'b0, 1'b0, req);
    @(negedge clk);
  endtask

  task automatic cmd(logic [1:0] op, logic [2:0] a, logic [2:0] d, logic v, string req);
    logic nv;
    bit bad;
    bad = (op == 2'b11) && (a == d);
    cmd_valid = 1'b1; cmd_op = op; src_a = a; dst = d; load_val = v;
    case (op)
      2'b00:   nv = v;
      2'b01:   nv = 1'b0;
      2'b10:   nv = 1'b1;
      default: nv = !model[a] | model[d];
    endcase
    if (!bad) model[d] = nv;
    push(cyc + 1, d, model[d], 1'b1, 1'b0, 1'b0, bad, req);
    push(cyc + 1, a, model[a], 1'b0, 1'b0, 1'b0, 1'b0, req);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic nand_run(logic [2:0] p, logic [2:0] q, logic [2:0] w,
                          int inj, bit collide, string req);
    int c;
    logic fin;
    c = cyc;
    nand_start = 1'b1; src_a = p; src_b = q; dst = w;
    if (collide) begin cmd_valid = 1'b1; cmd_op = 2'b10; end
    if (w == p || w == q) begin
      push(c + 1, w, model[w], 1'b1, 1'b0, 1'b0, 1'b1, req);
      push(c + 1, p, model[p], 1'b0, 1'b0, 1'b0, 1'b0, req);
      @(negedge clk);
      nand_start = 1'b0; cmd_valid = 1'b0;
      push(cyc + 1, w, model[w], 1'b1, 1'b0, 1'b0, 1'b0, req);
      @(negedge clk);
      return;
    end
    fin = !(model[p] & model[q]);
    push(c + 1, w, model[w], 1'b1, 1'b1, 1'b0, 1'b0, req);
    push(c + 2, w, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, req);
    push(c + 3, w, !model[p], 1'b1, 1'b1, 1'b0, 1'b0, req);
    push(c + 4, w, fin, 1'b1, 1'b0, 1'b1, 1'b0, req);
    push(c + 4, p, model[p], 1'b0, 1'b0, 1'b0, 1'b0, req);
    push(c + 4, q, model[q], 1'b0, 1'b0, 1'b0, 1'b0, req);
    @(negedge clk);
    nand_start = 1'b0; cmd_valid = 1'b0;
    if (inj >= 0) begin
      // R9: set and restart requests while busy
      nand_start = 1'b1; cmd_valid = 1'b1; cmd_op = 2'b10; dst = 3'(inj); src_a = 3'(inj);
      push(c + 4, 3'(inj), model[inj], 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    end
    @(negedge clk);
    @(negedge clk);
    nand_start = 1'b0; cmd_valid = 1'b0;
    model[w] = fin;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) push(cyc + 1, 3'(i), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    @(negedge clk);
    @(negedge clk);
    // R2: write value, set, clear
    cmd(2'b00, 3'd0, 3'd0, 1'b1, "R2");
    cmd(2'b00, 3'd0, 3'd1, 1'b0, "R2");
    cmd(2'b10, 3'd0, 3'd2, 1'b0, "R2");
    cmd(2'b00, 3'd0, 3'd3, 1'b1, "R2");
    cmd(2'b01, 3'd0, 3'd3, 1'b1, "R2");
    cmd(2'b10, 3'd0, 3'd6, 1'b0, "R2");
    // R3 / R4: all four source/target combinations
    cmd(2'b11, 3'd1, 3'd5, 1'b0, "R3");
    cmd(2'b11, 3'd0, 3'd3, 1'b0, "R3");
    cmd(2'b11, 3'd0, 3'd2, 1'b0, "R4");
    cmd(2'b11, 3'd1, 3'd6, 1'b0, "R4");
    cmd(2'b11, 3'd5, 3'd4, 1'b0, "R3");
    // R5: source equals target
    cmd(2'b11, 3'd2, 3'd2, 1'b0, "R5");
    cmd(2'b11, 3'd3, 3'd3, 1'b0, "R5");
    check_bank("R6");
    // R7: NAND truth table, working cell 7
    nand_run(3'd1, 3'd3, 3'd7, -1, 1'b0, "R7");
    nand_run(3'd0, 3'd3, 3'd7, -1, 1'b0, "R7");
    nand_run(3'd1, 3'd2, 3'd7, -1, 1'b0, "R7");
    nand_run(3'd0, 3'd2, 3'd7, 1, 1'b0, "R7");
    // R8: working cell overlaps an operand
    nand_run(3'd0, 3'd2, 3'd0, -1, 1'b0, "R8");
    nand_run(3'd0, 3'd2, 3'd2, -1, 1'b0, "R8");
    // R10: start and command together; cell 7 holds 0 so a set would show
    nand_run(3'd1, 3'd1, 3'd7, -1, 1'b1, "R10");
    check_bank("R6");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R6: %0d items never compared, expected 0", sb.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100us;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run hung, got no end, expected end");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule